// File: doc/BRIEF.md
# Clock-Crossing Counter Integrity Monitor

This block measures how cleanly a multi-bit count survives a crossing between two unrelated clocks. A free-running counter lives in the external clock domain and steps up by one on every rising edge of that clock. The system clock domain takes a fresh copy of that count on every one of its own edges. It then judges each new copy against the copy taken one cycle earlier. A copy that repeats the earlier value, or exceeds it by exactly one, is healthy. Every other step counts as a crossing fault.

Two tallies are kept in the system domain: how many judgements were made and how many of them were faults. A sticky flag records that a tally tried to go past its largest value. A single-cycle clear input restarts both tallies and drops the flag. A build-time parameter chooses how the count is captured: either one plain register or a chain of two or more synchronizing registers. Two builds can then run side by side and their fault rates can be compared.

Top module: `cdc_count_monitor`

## Requirements
- R1: While `sys_rst_n` is low, at every system clock edge `err_total`, `cmp_total` and `ovf` are all forced to zero.
- R2: The first system clock edge after reset only loads the reference copy and adds nothing to either tally. Hence, K edges after reset release with the source counter still, `cmp_total` reads K-1.
- R3: After seeding, every system clock edge on which `clr` is low adds exactly one to `cmp_total`, unless that tally is saturated.
- R4: A copy equal to the previous copy is healthy and leaves `err_total` unchanged. A stopped external clock therefore gives zero faults.
- R5: A copy exactly one above the previous copy is healthy. This is judged modulo 2^CNT_W, so the step from all ones to zero is healthy and is not a fault.
- R6: Any other difference between consecutive copies adds one to `err_total`. When the external clock runs at twice the system rate, every judgement is a fault.
- R7: Each tally holds at all ones instead of wrapping. The edge on which a tally at all ones would have advanced sets `ovf`, and `ovf` stays high until cleared.
- R8: At a system clock edge where `clr` is high, both tallies go to zero and `ovf` drops. The judgement made on that edge is discarded.
- R9: With SYNC_STAGES = 1, the count is captured by one plain register. With SYNC_STAGES >= 2, it passes through that many registers. When the external clock is slower than the system clock, both builds report the same tallies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ext_clk | input | 1 | External clock that advances the source counter |
| ext_rst_n | input | 1 | Active-low synchronous reset of the source counter (ext_clk domain) |
| sys_clk | input | 1 | System clock that samples and judges the count |
| sys_rst_n | input | 1 | Active-low synchronous reset of the system-domain logic |
| clr | input | 1 | Synchronous clear of both tallies and the overflow flag |
| err_total | output | TALLY_W | Number of judgements that found a disallowed step |
| cmp_total | output | TALLY_W | Number of judgements made |
| ovf | output | 1 | Sticky flag: a tally would have wrapped |

## Verification
On every system cycle the assertions check the following. Each tally moves by zero or one between clears. The fault tally never exceeds the judgement tally. A clear empties both tallies and the flag. A saturated tally stays saturated. The flag only rises after a tally reached all ones and then stays high. What those rules cannot show is whether a given step was judged correctly. That is left to the bench's scenarios: a stopped clock, slow clocks at ratios of 1:4, 1:40 and 1:400 (one of them long enough to wrap the source counter), a clock at twice the system rate, and a long fast run that saturates both tallies. The same scenarios also compare the plain-register build with the synchronizer build.

// File: rtl/cdcmon_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the clock-crossing counter monitor.
// Assumes: nothing beyond standard SystemVerilog.
package cdcmon_pkg;
    // Verdict on one step between consecutive captured copies.
    typedef enum logic [1:0] {
        STEP_SAME = 2'd0,
        STEP_NEXT = 2'd1,
        STEP_BAD  = 2'd2
    } step_e;
endpackage

// File: rtl/cdcmon_src_counter.sv
`timescale 1ns/1ps
// Module: cdcmon_src_counter
// Free-running up-counter in the external clock domain; wraps modulo 2^W.
// Assumes: rst_n is synchronous to clk.
module cdcmon_src_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    // Advance by one on every rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end
endmodule

// File: rtl/cdcmon_capture.sv
`timescale 1ns/1ps
// Module: cdcmon_capture
// Brings the external count into the system domain, either through one plain
// register (STAGES == 1) or through a chain of STAGES registers.
// Assumes: d is asynchronous to clk; STAGES >= 1.
module cdcmon_capture #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = (STAGES < 1) ? 0 : STAGES - 1;

    generate
        if (STAGES <= 1) begin : g_raw
            logic [W-1:0] cap_q;
            // Single capture register straight off the crossing.
            always_ff @(posedge clk) begin
                if (!rst_n) cap_q <= '0;
                else        cap_q <= d;
            end
            assign q = cap_q;
        end else begin : g_chain
            logic [W-1:0] stage_q [STAGES];
            // Shift the crossing value through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= d;
                    for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
                end
            end
            assign q = stage_q[LAST];
        end
    endgenerate
endmodule

// File: rtl/cdcmon_step_check.sv
`timescale 1ns/1ps
// Module: cdcmon_step_check
// Holds the previous captured copy and classifies the step to the current one.
// The first edge after reset only seeds the reference (valid stays low).
// Assumes: sample is already in the clk domain.
module cdcmon_step_check
    import cdcmon_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sample,
    output logic         valid,
    output step_e        kind
);
    logic [W-1:0] prev_q;
    logic         seeded_q;
    logic [W-1:0] delta;

    // Remember the copy just judged and note that a reference exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            seeded_q <= 1'b0;
        end else begin
            prev_q   <= sample;
            seeded_q <= 1'b1;
        end
    end

    assign delta = sample - prev_q;
    assign valid = seeded_q;

    // Modular difference: 0 is a hold, 1 is a legal advance, else a fault.
    always_comb begin
        if (delta == '0)                  kind = STEP_SAME;
        else if (delta == {{(W-1){1'b0}}, 1'b1}) kind = STEP_NEXT;
        else                              kind = STEP_BAD;
    end
endmodule

// File: rtl/cdcmon_sat_tally.sv
`timescale 1ns/1ps
// Module: cdcmon_sat_tally
// Saturating event tally with synchronous clear; reports an attempted wrap.
// Assumes: clr takes priority over inc.
module cdcmon_sat_tally #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         wrap_hit
);
    logic at_top;
    assign at_top   = &count;
    assign wrap_hit = inc && !clr && at_top;

    // Count events, hold at all ones, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)              count <= '0;
        else if (clr)            count <= '0;
        else if (inc && !at_top) count <= count + 1'b1;
    end
endmodule

// File: rtl/cdc_count_monitor.sv
`timescale 1ns/1ps
// Module: cdc_count_monitor (top)
// Counts external clock edges, carries the count into the system domain and
// tallies judgements and disallowed steps, with a sticky overflow flag.
// Assumes: ext_clk and sys_clk are unrelated; every output is registered on
// sys_clk; SYNC_STAGES = 1 selects the plain capture register.
module cdc_count_monitor
    import cdcmon_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int TALLY_W     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               ext_clk,
    input  logic               ext_rst_n,
    input  logic               sys_clk,
    input  logic               sys_rst_n,
    input  logic               clr,
    output logic [TALLY_W-1:0] err_total,
    output logic [TALLY_W-1:0] cmp_total,
    output logic               ovf
);
    localparam int CAP_STAGES = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

    logic [CNT_W-1:0] src_count;
    logic [CNT_W-1:0] sys_copy;
    logic             judge_valid;
    step_e            judge_kind;
    logic             cmp_wrap;
    logic             err_wrap;
    logic             err_inc;

    cdcmon_src_counter #(.W(CNT_W)) u_src (
        .clk   (ext_clk),
        .rst_n (ext_rst_n),
        .count (src_count)
    );

    cdcmon_capture #(.W(CNT_W), .STAGES(CAP_STAGES)) u_cap (
        .clk   (sys_clk),
        .rst_n (sys_rst_n),
        .d     (src_count),
        .q     (sys_copy)
    );

    cdcmon_step_check #(.W(CNT_W)) u_judge (
        .clk    (sys_clk),
        .rst_n  (sys_rst_n),
        .sample (sys_copy),
        .valid  (judge_valid),
        .kind   (judge_kind)
    );

    assign err_inc = judge_valid && (judge_kind == STEP_BAD);

    cdcmon_sat_tally #(.W(TALLY_W)) u_cmp_tally (
        .clk      (sys_clk),
        .rst_n    (sys_rst_n),
        .clr      (clr),
        .inc      (judge_valid),
        .count    (cmp_total),
        .wrap_hit (cmp_wrap)
    );

    cdcmon_sat_tally #(.W(TALLY_W)) u_err_tally (
        .clk      (sys_clk),
        .rst_n    (sys_rst_n),
        .clr      (clr),
        .inc      (err_inc),
        .count    (err_total),
        .wrap_hit (err_wrap)
    );

    // Latch any attempted tally wrap until the next clear.
    always_ff @(posedge sys_clk) begin
        if (!sys_rst_n)               ovf <= 1'b0;
        else if (clr)                 ovf <= 1'b0;
        else if (cmp_wrap || err_wrap) ovf <= 1'b1;
    end
endmodule

// File: rtl/cdcmon_checker.sv
`timescale 1ns/1ps
// Module: cdcmon_checker
// Cycle-by-cycle rules on the monitor outputs; bound into every instance.
// Assumes: observes only the top-level ports in the system clock domain.
module cdcmon_checker #(
    parameter int TALLY_W = 32
) (
    input logic               sys_clk,
    input logic               sys_rst_n,
    input logic               clr,
    input logic [TALLY_W-1:0] err_total,
    input logic [TALLY_W-1:0] cmp_total,
    input logic               ovf
);
    assert_cmp_step_R3: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !clr |=> (cmp_total == $past(cmp_total)) || (cmp_total == $past(cmp_total) + 1'b1));

    assert_err_step_R6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        !clr |=> (err_total == $past(err_total)) || (err_total == $past(err_total) + 1'b1));

    assert_err_bounded_R6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        err_total <= cmp_total);

    assert_clear_R8: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        clr |=> (cmp_total == '0) && (err_total == '0) && !ovf);

    assert_ovf_sticky_R7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        ovf && !clr |=> ovf);

    assert_saturate_R7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (&cmp_total) && !clr |=> (&cmp_total));

    assert_ovf_cause_R7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $rose(ovf) |-> $past(&cmp_total) || $past(&err_total));
endmodule

bind cdc_count_monitor cdcmon_checker #(.TALLY_W(TALLY_W)) u_chk (
    .sys_clk   (sys_clk),
    .sys_rst_n (sys_rst_n),
    .clr       (clr),
    .err_total (err_total),
    .cmp_total (cmp_total),
    .ovf       (ovf)
);

// File: tb/cdc_count_monitor_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected tallies per scenario window;
// the monitor pops each item at the next falling edge and compares both builds.
module cdc_count_monitor_tb;
    localparam int CNT_W   = 10;
    localparam int TALLY_W = 13;
    localparam int TOP     = (1 << TALLY_W) - 1;

    typedef struct {
        string req;
        int    err;
        int    cmp;
        bit    ovf;
    } item_t;

    logic sys_clk   = 1'b0;
    logic ext_clk   = 1'b0;
    logic sys_rst_n = 1'b0;
    logic ext_rst_n = 1'b0;
    logic clr       = 1'b0;
    real  ext_half  = 1.0;
    bit   done      = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;
    item_t exp_q[$];

    logic [TALLY_W-1:0] err_s, cmp_s, err_r, cmp_r;
    logic               ovf_s, ovf_r;

    cdc_count_monitor #(.CNT_W(CNT_W), .TALLY_W(TALLY_W), .SYNC_STAGES(2)) u_dut (
        .ext_clk(ext_clk), .ext_rst_n(ext_rst_n), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
        .clr(clr), .err_total(err_s), .cmp_total(cmp_s), .ovf(ovf_s));

    cdc_count_monitor #(.CNT_W(CNT_W), .TALLY_W(TALLY_W), .SYNC_STAGES(1)) u_raw (
        .ext_clk(ext_clk), .ext_rst_n(ext_rst_n), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
        .clr(clr), .err_total(err_r), .cmp_total(cmp_r), .ovf(ovf_r));

    always #2 sys_clk = ~sys_clk;

    // External clock, offset by half a nanosecond so its edges never meet sys_clk edges.
    initial begin
        #0.5;
        forever begin
            if (ext_half == 0.0) #1;
            else begin
                #(ext_half);
                ext_clk = ~ext_clk;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compare both builds against the expected item.
    always @(negedge sys_clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            check({it.req, " sync err"}, int'(err_s), it.err);
            check({it.req, " sync cmp"}, int'(cmp_s), it.cmp);
            check({it.req, " sync ovf"}, int'(ovf_s), int'(it.ovf));
            check({it.req, " R9 raw err"}, int'(err_r), it.err);
            check({it.req, " R9 raw cmp"}, int'(cmp_r), it.cmp);
            check({it.req, " R9 raw ovf"}, int'(ovf_r), int'(it.ovf));
        end
    end

    task automatic push(input string req, input int e, input int c, input bit o);
        item_t it;
        it.req = req; it.err = e; it.cmp = c; it.ovf = o;
        exp_q.push_back(it);
    endtask

    // Driver: set the external rate, settle, clear, run m judgements, push expectation.
    task automatic run_window(input string req, input real half, input int m,
                              input int e, input int c, input bit o);
        ext_half = half;
        repeat (250) @(posedge sys_clk);
        @(negedge sys_clk) clr = 1'b1;
        @(negedge sys_clk) clr = 1'b0;
        repeat (m) @(posedge sys_clk);
        push(req, e, c, o);
    endtask

    initial begin
        // R1: reset state with the external clock running.
        repeat (20) @(posedge sys_clk);
        push("R1", 0, 0, 1'b0);
        ext_half = 0.0;
        repeat (250) @(posedge sys_clk);
        // R2: seeding edge is not counted.
        @(negedge sys_clk);
        sys_rst_n = 1'b1;
        ext_rst_n = 1'b1;
        repeat (20) @(posedge sys_clk);
        push("R2", 0, 19, 1'b0);
        // R4: stopped clock gives holds only; R3 one judgement per edge.
        run_window("R4 R3 stopped", 0.0, 50, 0, 50, 1'b0);
        // R5: ratio 1:4, long enough to wrap the 10-bit source counter.
        run_window("R5 ratio4 wrap", 8.0, 5000, 0, 5000, 1'b0);
        run_window("R5 ratio40", 80.0, 1000, 0, 1000, 1'b0);
        run_window("R5 ratio400", 800.0, 3000, 0, 3000, 1'b0);
        // R6: twice the system rate, every step is two.
        run_window("R6 fast", 1.0, 100, 100, 100, 1'b0);
        // R7: saturation and sticky flag.
        run_window("R7 saturate", 1.0, 9000, TOP, TOP, 1'b1);
        // R8: clear drops the flag and restarts both tallies.
        run_window("R8 clear", 1.0, 1, 1, 1, 1'b0);
        repeat (3) @(negedge sys_clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_fails, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge sys_clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_fails, n_checks);
            $finish;
        end
    end
endmodule